// File: doc/BRIEF.md
# Tagged Next-Block Prefetch Trigger

This block sits beside a cache controller and decides when to fetch blocks ahead of demand. It watches every demand access (block number, hit or miss, cache line index). When an access qualifies as a trigger, it queues a request for the blocks after the accessed block b, that is b+1 up to b+K. It keeps one marker bit per cache line that records whether the line was brought in by a prefetch and has not been used yet. The first demand hit on such a line counts as a trigger in the tagged modes. A sequential stream therefore keeps running ahead of the processor without waiting for a miss.

Queued triggers are expanded one candidate block per cycle. Each candidate is first checked against the cache tags through a probe port. A candidate that is already present is dropped; any other candidate leaves as a prefetch request one cycle later. The degree K either comes from a configuration input or, in adaptive mode, from an internal controller. That controller counts issued prefetches and first-use hits, and moves K by one step at the end of each evaluation window.

Top module: `pf_obl_prefetcher`

## Requirements
- R1: A demand miss on block b, in every mode, triggers requests for blocks b+1 through b+K, in increasing order, computed modulo 2^26.
- R2: In miss-only mode (`mode` = 2'b00), no demand hit ever produces a prefetch request, even if the line's marker bit is set.
- R3: In the tagged modes (`mode` = 2'b01, 2'b10 or 2'b11), a demand hit on a line whose marker bit is 1 triggers like a miss and clears the bit, so a second hit on that line triggers nothing. A hit clears a set bit in every mode.
- R4: A fill with `fill_pf` = 1 sets the marker bit of `fill_line`, and a fill with `fill_pf` = 0 clears it. A hit on a demand-filled line never triggers.
- R5: Outside adaptive mode, K equals `cfg_degree`, except that 0 acts as 1 and values above KMAX (8) act as KMAX.
- R6: At most one candidate is probed per cycle. A candidate whose probe reports present is dropped. Any other candidate appears on `pf_valid`/`pf_block` in the cycle after its probe.
- R7: Triggers wait in a first-in first-out queue of DEPTH (4) entries and are served in arrival order. A trigger that arrives while the queue is full is discarded.
- R8: In adaptive mode (`mode` = 2'b10), K starts at 1 after reset and `cfg_degree` is ignored. At the end of every WINDOW issued requests, K rises by one if at least half as many first-use hits occurred in that window, and falls by one if fewer than a quarter occurred. K always stays within 1 and KMAX.
- R9: Reset empties the queue, clears every marker bit, and keeps `probe_valid` and `pf_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 miss-only, 01 tagged, 10 tagged adaptive, 11 tagged |
| cfg_degree | input | 4 | Fixed degree K outside adaptive mode |
| acc_valid | input | 1 | Demand access this cycle |
| acc_block | input | 26 | Block number of the access |
| acc_hit | input | 1 | Access hit in the cache |
| acc_line | input | LINE_W | Cache line index of the access |
| fill_valid | input | 1 | A line is being filled this cycle |
| fill_line | input | LINE_W | Line index being filled |
| fill_pf | input | 1 | Fill was caused by a prefetch |
| probe_valid | output | 1 | Tag probe for a candidate block |
| probe_block | output | 26 | Candidate block number being probed |
| probe_hit | input | 1 | Same-cycle answer: candidate already present |
| pf_valid | output | 1 | Prefetch request |
| pf_block | output | 26 | Block number requested |

## Verification
The assertions take for granted that `probe_hit` answers the probe in the same cycle. They also assume that an access and a fill never name the same line in the same cycle, since the outcome of such a clash is left to the fill. The stimulus keeps fills and accesses in separate cycles, and derives its probe answer combinationally from its own record of cached blocks. Before the adaptive checks, the bench applies a fresh reset, so the window count starts from zero.

// File: rtl/pf_pkg.sv
package pf_pkg;

    localparam int PF_BLK_W = 26;
    localparam int PF_DEG_W = 4;

    typedef logic [PF_BLK_W-1:0] blk_t;
    typedef logic [PF_DEG_W-1:0] deg_t;

    typedef enum logic [1:0] {
        PF_MODE_MISS    = 2'b00,
        PF_MODE_TAG     = 2'b01,
        PF_MODE_ADAPT   = 2'b10,
        PF_MODE_TAG_ALT = 2'b11
    } pf_mode_e;

    typedef struct packed {
        blk_t base;
        deg_t k;
    } pf_trig_t;

    function automatic deg_t clamp_degree(input deg_t d, input deg_t kmax);
        if (d == '0)  return deg_t'(1);
        if (d > kmax) return kmax;
        return d;
    endfunction

    function automatic logic mode_is_tagged(input pf_mode_e m);
        return m != PF_MODE_MISS;
    endfunction

endpackage

// File: rtl/pf_tag_array.sv
module pf_tag_array #(
    parameter int LINE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_valid,
    input  logic [LINE_W-1:0] clr_line,
    input  logic              fill_valid,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              fill_pf,
    input  logic [LINE_W-1:0] rd_line,
    output logic              rd_bit
);
    localparam int LINES = 1 << LINE_W;

    logic [LINES-1:0] mark_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mark_q <= '0;
        end else begin
            for (int i = 0; i < LINES; i++) begin
                if (fill_valid && fill_line == LINE_W'(i))
                    mark_q[i] <= fill_pf;
                else if (clr_valid && clr_line == LINE_W'(i))
                    mark_q[i] <= 1'b0;
            end
        end
    end

    assign rd_bit = mark_q[rd_line];

endmodule

// File: rtl/pf_req_queue.sv
module pf_req_queue
    import pf_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  pf_trig_t         push_data,
    input  logic             pop,
    output pf_trig_t         head,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    pf_trig_t         slots_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign count   = cnt_q;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = slots_q[rd_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) slots_q[i] <= '0;
        end else begin
            if (do_push) begin
                slots_q[wr_q] <= push_data;
                wr_q          <= bump(wr_q);
            end
            if (do_pop) rd_q <= bump(rd_q);
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/pf_issue.sv
module pf_issue
    import pf_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     head_valid,
    input  pf_trig_t head,
    input  logic     probe_hit,
    output logic     pop,
    output logic     probe_valid,
    output blk_t     probe_block,
    output logic     issue_evt,
    output logic     pf_valid,
    output blk_t     pf_block
);
    deg_t offset_q;
    logic last_cand;

    assign probe_valid = head_valid;
    assign probe_block = head.base + blk_t'(offset_q);
    assign last_cand   = (offset_q >= head.k);
    assign pop         = head_valid && last_cand;
    assign issue_evt   = head_valid && !probe_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            offset_q <= deg_t'(1);
            pf_valid <= 1'b0;
            pf_block <= '0;
        end else begin
            pf_valid <= issue_evt;
            pf_block <= probe_block;
            if (head_valid)
                offset_q <= last_cand ? deg_t'(1) : offset_q + 1'b1;
        end
    end

endmodule

// File: rtl/pf_degree_ctl.sv
module pf_degree_ctl
    import pf_pkg::*;
#(
    parameter int WINDOW = 256,
    parameter int KMAX   = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic issue_evt,
    input  logic useful_evt,
    output deg_t k_cur
);
    localparam int ISS_W = (WINDOW > 2) ? $clog2(WINDOW) : 1;
    localparam int USE_W = $clog2(WINDOW + 1);

    logic [ISS_W-1:0] iss_q;
    logic [USE_W-1:0] use_q, use_next;
    deg_t             k_q;
    logic             window_end, go_up, go_down;

    assign window_end = issue_evt && (iss_q == ISS_W'(WINDOW - 1));
    assign go_up      = (int'(use_q) * 2 >= WINDOW);
    assign go_down    = (int'(use_q) * 4 <  WINDOW);

    always_comb begin
        use_next = use_q;
        if (useful_evt && use_q != USE_W'(WINDOW)) use_next = use_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            k_q   <= deg_t'(1);
            iss_q <= '0;
            use_q <= '0;
        end else if (window_end) begin
            iss_q <= '0;
            use_q <= USE_W'(useful_evt);
            if (go_up) begin
                if (k_q < deg_t'(KMAX)) k_q <= k_q + 1'b1;
            end else if (go_down) begin
                if (k_q > deg_t'(1)) k_q <= k_q - 1'b1;
            end
        end else begin
            if (issue_evt) iss_q <= iss_q + 1'b1;
            use_q <= use_next;
        end
    end

    assign k_cur = k_q;

endmodule

// File: rtl/pf_obl_prefetcher.sv
module pf_obl_prefetcher
    import pf_pkg::*;
#(
    parameter int LINE_W = 6,
    parameter int DEPTH  = 4,
    parameter int KMAX   = 8,
    parameter int WINDOW = 256
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          mode,
    input  logic [PF_DEG_W-1:0] cfg_degree,
    input  logic                acc_valid,
    input  logic [PF_BLK_W-1:0] acc_block,
    input  logic                acc_hit,
    input  logic [LINE_W-1:0]   acc_line,
    input  logic                fill_valid,
    input  logic [LINE_W-1:0]   fill_line,
    input  logic                fill_pf,
    output logic                probe_valid,
    output logic [PF_BLK_W-1:0] probe_block,
    input  logic                probe_hit,
    output logic                pf_valid,
    output logic [PF_BLK_W-1:0] pf_block
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    pf_mode_e         mode_e;
    logic             mark_bit, useful_evt, trig_valid;
    deg_t             k_fix, k_adapt, k_eff;
    pf_trig_t         trig;
    pf_trig_t         q_head;
    logic             q_empty, q_full, q_pop, issue_evt;
    logic [CNT_W-1:0] q_count;

    assign mode_e = pf_mode_e'(mode);

    pf_tag_array #(.LINE_W(LINE_W)) u_marks (
        .clk        (clk),
        .rst        (rst),
        .clr_valid  (useful_evt),
        .clr_line   (acc_line),
        .fill_valid (fill_valid),
        .fill_line  (fill_line),
        .fill_pf    (fill_pf),
        .rd_line    (acc_line),
        .rd_bit     (mark_bit)
    );

    assign k_fix      = clamp_degree(cfg_degree, deg_t'(KMAX));
    assign k_eff      = (mode_e == PF_MODE_ADAPT) ? k_adapt : k_fix;
    assign useful_evt = acc_valid && acc_hit && mark_bit;
    assign trig_valid = acc_valid && (!acc_hit || (mode_is_tagged(mode_e) && mark_bit));
    assign trig       = '{base: acc_block, k: k_eff};

    pf_req_queue #(.DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .push      (trig_valid),
        .push_data (trig),
        .pop       (q_pop),
        .head      (q_head),
        .empty     (q_empty),
        .full      (q_full),
        .count     (q_count)
    );

    pf_issue u_issue (
        .clk         (clk),
        .rst         (rst),
        .head_valid  (!q_empty),
        .head        (q_head),
        .probe_hit   (probe_hit),
        .pop         (q_pop),
        .probe_valid (probe_valid),
        .probe_block (probe_block),
        .issue_evt   (issue_evt),
        .pf_valid    (pf_valid),
        .pf_block    (pf_block)
    );

    pf_degree_ctl #(.WINDOW(WINDOW), .KMAX(KMAX)) u_degree (
        .clk        (clk),
        .rst        (rst),
        .issue_evt  (issue_evt),
        .useful_evt (useful_evt),
        .k_cur      (k_adapt)
    );

endmodule

// File: rtl/pf_obl_prefetcher_chk.sv
module pf_obl_prefetcher_chk #(
    parameter int DEPTH = 4,
    parameter int KMAX  = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       mode,
    input logic             acc_valid,
    input logic             acc_hit,
    input logic             probe_valid,
    input logic [25:0]      probe_block,
    input logic             probe_hit,
    input logic             pf_valid,
    input logic [25:0]      pf_block,
    input logic             q_push,
    input logic [CNT_W-1:0] q_count,
    input logic [3:0]       k_adapt
);
    // R6: a request only follows a probe that found the block absent
    p_pf_follows_probe_r6: assert property (@(posedge clk) disable iff (rst)
        pf_valid |-> ($past(probe_valid) && !$past(probe_hit)));

    // R6: the requested block is the one that was probed
    p_pf_block_r6: assert property (@(posedge clk) disable iff (rst)
        pf_valid |-> (pf_block == $past(probe_block)));

    // R2: miss-only mode never queues on a hit
    p_onmiss_hit_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00 && acc_valid && acc_hit) |-> !q_push);

    // R1: every miss offers a trigger to the queue
    p_miss_pushes_r1: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_hit) |-> q_push);

    // R7: occupancy never exceeds the queue depth
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        int'(q_count) <= DEPTH);

    // R7: occupancy moves by at most one entry per cycle
    p_count_step_r7: assert property (@(posedge clk) disable iff (rst)
        (int'(q_count) == int'($past(q_count)) ||
         int'(q_count) == int'($past(q_count)) + 1 ||
         int'(q_count) == int'($past(q_count)) - 1));

    // R8: adaptive degree stays in range
    p_degree_range_r8: assert property (@(posedge clk) disable iff (rst)
        (int'(k_adapt) >= 1 && int'(k_adapt) <= KMAX));

    // R8: adaptive degree moves one step at a time
    p_degree_step_r8: assert property (@(posedge clk) disable iff (rst)
        (k_adapt != $past(k_adapt)) |->
        (int'(k_adapt) == int'($past(k_adapt)) + 1 ||
         int'(k_adapt) == int'($past(k_adapt)) - 1));

endmodule

bind pf_obl_prefetcher pf_obl_prefetcher_chk #(.DEPTH(DEPTH), .KMAX(KMAX)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode        (mode),
    .acc_valid   (acc_valid),
    .acc_hit     (acc_hit),
    .probe_valid (probe_valid),
    .probe_block (probe_block),
    .probe_hit   (probe_hit),
    .pf_valid    (pf_valid),
    .pf_block    (pf_block),
    .q_push      (trig_valid),
    .q_count     (q_count),
    .k_adapt     (k_adapt)
);

// File: tb/tb_pf_obl_prefetcher.sv
module tb_pf_obl_prefetcher;

    localparam int CLK_PERIOD = 10;
    localparam int LINE_W = 6;
    localparam int LINES  = 1 << LINE_W;
    localparam int DEPTH  = 4;
    localparam int KMAX   = 8;
    localparam int WIN    = 16;
    localparam int MASK   = (1 << 26) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        mode = 2'b00;
    logic [3:0]        cfg_degree = 4'd1;
    logic              acc_valid = 1'b0;
    logic [25:0]       acc_block = '0;
    logic              acc_hit = 1'b0;
    logic [LINE_W-1:0] acc_line = '0;
    logic              fill_valid = 1'b0;
    logic [LINE_W-1:0] fill_line = '0;
    logic              fill_pf = 1'b0;
    logic              probe_valid;
    logic [25:0]       probe_block;
    logic              probe_hit;
    logic              pf_valid;
    logic [25:0]       pf_block;

    pf_obl_prefetcher #(.LINE_W(LINE_W), .DEPTH(DEPTH), .KMAX(KMAX), .WINDOW(WIN)) dut (
        .clk(clk), .rst(rst), .mode(mode), .cfg_degree(cfg_degree),
        .acc_valid(acc_valid), .acc_block(acc_block), .acc_hit(acc_hit), .acc_line(acc_line),
        .fill_valid(fill_valid), .fill_line(fill_line), .fill_pf(fill_pf),
        .probe_valid(probe_valid), .probe_block(probe_block), .probe_hit(probe_hit),
        .pf_valid(pf_valid), .pf_block(pf_block)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // cache contents as seen by the bench
    bit present [int];
    int map_ver = 0;
    always @(probe_block or map_ver) probe_hit = present.exists(int'(probe_block));

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    int  mq_base [$];
    int  mq_k [$];
    int  m_off = 1;
    bit  m_mark [LINES];
    int  m_k = 1, m_iss = 0, m_use = 0;
    bit  e_pf_v = 1'b0;
    int  e_pf_b = 0;
    int  pf_seen [$];

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic model_reset();
        mq_base.delete(); mq_k.delete();
        m_off = 1; m_k = 1; m_iss = 0; m_use = 0;
        e_pf_v = 1'b0; e_pf_b = 0;
        foreach (m_mark[i]) m_mark[i] = 1'b0;
    endtask

    function automatic int clampk(input int d);
        if (d == 0) return 1;
        if (d > KMAX) return KMAX;
        return d;
    endfunction

    task automatic model_step();
        int  sz0 = mq_base.size();
        int  keff = (mode == 2'b10) ? m_k : clampk(int'(cfg_degree));
        bit  mk = m_mark[acc_line];
        bit  trig = acc_valid && (!acc_hit || (mode != 2'b00 && mk));
        bit  useful = acc_valid && acc_hit && mk;
        bit  issue = 1'b0;
        int  cand;
        if (sz0 > 0) begin
            cand = (mq_base[0] + m_off) & MASK;
            issue = !present.exists(cand);
            e_pf_v = issue;
            e_pf_b = cand;
            if (m_off >= mq_k[0]) begin
                void'(mq_base.pop_front()); void'(mq_k.pop_front()); m_off = 1;
            end else m_off++;
        end else e_pf_v = 1'b0;
        if (trig && sz0 < DEPTH) begin
            mq_base.push_back(int'(acc_block)); mq_k.push_back(keff);
        end
        if (useful) m_mark[acc_line] = 1'b0;
        if (fill_valid) m_mark[fill_line] = fill_pf;
        if (issue && m_iss == WIN - 1) begin
            if (m_use * 2 >= WIN) begin
                if (m_k < KMAX) m_k++;
            end else if (m_use * 4 < WIN) begin
                if (m_k > 1) m_k--;
            end
            m_iss = 0;
            m_use = useful ? 1 : 0;
        end else begin
            if (issue) m_iss++;
            if (useful && m_use < WIN) m_use++;
        end
    endtask

    task automatic compare();
        bit ev = mq_base.size() > 0;
        chk(probe_valid === ev, "R6 probe_valid", int'(probe_valid), int'(ev));
        if (ev && probe_valid === 1'b1)
            chk(int'(probe_block) == ((mq_base[0] + m_off) & MASK), "R6 probe_block",
                int'(probe_block), (mq_base[0] + m_off) & MASK);
        chk(pf_valid === e_pf_v, "R6 pf_valid", int'(pf_valid), int'(e_pf_v));
        if (e_pf_v && pf_valid === 1'b1)
            chk(int'(pf_block) == e_pf_b, "R6 pf_block", int'(pf_block), e_pf_b);
        if (pf_valid === 1'b1) pf_seen.push_back(int'(pf_block));
    endtask

    task automatic cycle();
        #1;
        if (!rst) compare();
        @(posedge clk);
        if (rst) model_reset(); else model_step();
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
    endtask

    task automatic access(input int blk, input bit hit, input int line);
        acc_valid = 1'b1; acc_block = 26'(blk); acc_hit = hit; acc_line = LINE_W'(line);
        cycle();
        acc_valid = 1'b0; acc_hit = 1'b0;
    endtask

    task automatic fill(input int line, input bit pf, input int blk);
        fill_valid = 1'b1; fill_line = LINE_W'(line); fill_pf = pf;
        present[blk] = 1'b1; map_ver++;
        cycle();
        fill_valid = 1'b0;
    endtask

    task automatic watch(input string tag, input int n_exp, input int first_exp);
        chk(pf_seen.size() == n_exp, {tag, " request count"}, pf_seen.size(), n_exp);
        if (n_exp > 0 && pf_seen.size() > 0)
            chk(pf_seen[0] == first_exp, {tag, " first block"}, pf_seen[0], first_exp);
        pf_seen.delete();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: run did not end actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R9: outputs quiet after reset
        #1;
        chk(probe_valid === 1'b0, "R9 probe_valid after reset", int'(probe_valid), 0);
        chk(pf_valid === 1'b0, "R9 pf_valid after reset", int'(pf_valid), 0);
        @(negedge clk);

        // R1: miss in miss-only mode, K = 1
        mode = 2'b00; cfg_degree = 4'd1; pf_seen.delete();
        access(100, 1'b0, 3); idle(4);
        watch("R1 miss b+1", 1, 101);

        // R1: block number wraps modulo 2^26
        cfg_degree = 4'd2;
        access(MASK, 1'b0, 4); idle(5);
        chk(pf_seen.size() == 2, "R1 wrap count", pf_seen.size(), 2);
        if (pf_seen.size() == 2) chk(pf_seen[1] == 1, "R1 wrap second", pf_seen[1], 1);
        pf_seen.delete();

        // R2: hit on a prefetched line does nothing in miss-only mode
        cfg_degree = 4'd1;
        fill(5, 1'b1, 101); idle(2);
        access(101, 1'b1, 5); idle(4);
        watch("R2 hit quiet", 0, 0);

        // R3: tagged mode, first hit on prefetched line triggers, second does not
        mode = 2'b01;
        fill(5, 1'b1, 110); idle(1);
        access(110, 1'b1, 5); idle(4);
        watch("R3 first use", 1, 111);
        access(110, 1'b1, 5); idle(4);
        watch("R3 second use", 0, 0);

        // R3: encoding 11 behaves as tagged
        mode = 2'b11;
        fill(8, 1'b1, 150); idle(1);
        access(150, 1'b1, 8); idle(4);
        watch("R3 mode 11", 1, 151);

        // R4: demand fill leaves marker clear; demand fill overwrites a set marker
        mode = 2'b01;
        fill(6, 1'b0, 120); idle(1);
        access(120, 1'b1, 6); idle(4);
        watch("R4 demand line", 0, 0);
        fill(7, 1'b1, 130); fill(7, 1'b0, 140); idle(1);
        access(140, 1'b1, 7); idle(4);
        watch("R4 refilled line", 0, 0);

        // R5: fixed degree and its clamping
        mode = 2'b00; cfg_degree = 4'd3;
        access(200, 1'b0, 9); idle(6);
        watch("R5 degree 3", 3, 201);
        cfg_degree = 4'd0;
        access(210, 1'b0, 9); idle(4);
        watch("R5 degree 0", 1, 211);
        cfg_degree = 4'd15;
        access(220, 1'b0, 9); idle(12);
        watch("R5 degree 15", KMAX, 221);

        // R6: candidate already cached is dropped
        cfg_degree = 4'd3;
        fill(10, 1'b0, 301); idle(1);
        access(300, 1'b0, 11); idle(6);
        watch("R6 drop present", 2, 302);

        // R7: six back-to-back triggers, queue holds four, order kept
        cfg_degree = 4'd8;
        for (int i = 0; i < 6; i++) access(400 + 20 * i, 1'b0, 12);
        idle(40);
        chk(pf_seen.size() == 4 * KMAX, "R7 overflow count", pf_seen.size(), 4 * KMAX);
        if (pf_seen.size() == 4 * KMAX) begin
            chk(pf_seen[KMAX] == 421, "R7 order second", pf_seen[KMAX], 421);
            chk(pf_seen[3 * KMAX + 7] == 468, "R7 order last", pf_seen[3 * KMAX + 7], 468);
        end
        pf_seen.delete();

        // R9: reset clears markers
        mode = 2'b01; cfg_degree = 4'd1;
        fill(13, 1'b1, 600); idle(1);
        do_reset();
        access(600, 1'b1, 13); idle(4);
        watch("R9 markers cleared", 0, 0);

        // R8: adaptive degree, fresh window after reset
        do_reset();
        mode = 2'b10; cfg_degree = 4'd5;
        access(900, 1'b0, 1); idle(4);
        watch("R8 start at 1", 1, 901);
        do_reset();
        for (int i = 0; i < 8; i++) begin
            access(1000 + 2 * i, 1'b0, i); idle(4);
            fill(32 + i, 1'b1, 1001 + 2 * i); idle(1);
            access(1001 + 2 * i, 1'b1, 32 + i); idle(4);
        end
        pf_seen.delete();
        access(2000, 1'b0, 20); idle(5);
        watch("R8 raised to 2", 2, 2001);
        for (int i = 0; i < 7; i++) begin
            access(3000 + 10 * i, 1'b0, 21); idle(5);
        end
        pf_seen.delete();
        access(5000, 1'b0, 22); idle(5);
        watch("R8 lowered to 1", 1, 5001);

        finish_run();
    end

endmodule